// File: doc/BRIEF.md
# DDR Interface Test-Pattern Error Detector

This block watches a double-data-rate sample interface while it carries a known repeating test pattern and reports which data bits arrive wrong. Each valid clock cycle delivers two sample words, one captured on the rising edge and one on the falling edge. The block checks both words against a short pattern that software loads beforehand as eight bytes, which form four 16-bit words. The pattern length is programmable as one, two or four words. For the four-word length, a frame strobe marks the cycle that carries the start of the pattern. Any bit that differs sets a per-bit failure flag, kept separately for the rising and falling lanes. It also sets a latched interrupt status. A mask gates that status onto one of two request outputs.

A small state machine governs the flags. OFF is entered whenever the enable input is low, and nothing is compared there. On enable, OFF goes to CHECK when no flags are held, or to FAIL when flags are still set. CHECK goes to FAIL on a mismatch. In sticky mode FAIL holds until the clear input is raised. In automatic mode a matching valid cycle takes FAIL to RECOVER. RECOVER counts consecutive matching valid cycles and returns to CHECK, wiping the flags, when the count is complete. A mismatch in RECOVER sends it back to FAIL, and so does turning automatic mode off. Clear takes every state to CHECK, or to OFF when the enable input is low.

Top module: `ddr_pattern_checker`

## Requirements
- R1: Byte address a (0 to 7) of the pattern store writes pattern word a/2. An even address writes bits 7:0 of that word and an odd address writes bits 15:8.
- R2: With depth code 0 (one word), both the rising and the falling sample of every valid cycle are compared against word 0.
- R3: With depth code 1 (two words), every valid cycle compares its rising sample against word 0 and its falling sample against word 1.
- R4: With depth code 2 or 3 (four words), valid cycles alternate between the pairs (word 0, word 1) and (word 2, word 3). The first pair is used first after reset or after any valid cycle at a shorter depth. A valid cycle with frame high always uses (word 0, word 1), and the cycle after it uses (word 2, word 3).
- R5: Each mismatching bit sets the matching bit of the rising or falling flag vector. The update is visible after the clock edge that captures the sample.
- R6: With automatic mode low, flags only accumulate. They never clear without the clear input.
- R7: With automatic mode high, the flags return to zero after CLEAR_RUN (8) consecutive matching valid cycles. A mismatch restarts the count, and the interrupt status stays set.
- R8: Clear zeroes both flag vectors and the interrupt status. It takes priority over a mismatching sample in the same cycle.
- R9: While the enable input is low, samples are ignored: flags and interrupt status hold.
- R10: Any recorded mismatch sets the interrupt status. Request output irq_req[irq_route] equals the status ANDed with irq_mask, and the other request output stays low.
- R11: After reset, both flag vectors, the interrupt status and both request outputs are zero, and the pattern store holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern byte write strobe |
| pat_addr | input | 3 | Pattern byte address |
| pat_wdata | input | 8 | Pattern byte data |
| chk_enable | input | 1 | Comparison enable |
| auto_mode | input | 1 | 1 = automatic flag clearing, 0 = sticky flags |
| depth_sel | input | 2 | Pattern length: 0 one word, 1 two words, 2/3 four words |
| flag_clear | input | 1 | Clears flags and interrupt status |
| irq_mask | input | 1 | Interrupt enable |
| irq_route | input | 1 | Selects which request output carries the interrupt |
| smp_valid | input | 1 | Sample pair valid this cycle |
| smp_frame | input | 1 | Marks the cycle whose samples are pattern words 0 and 1 |
| smp_rise | input | 16 | Sample captured on the rising edge |
| smp_fall | input | 16 | Sample captured on the falling edge |
| flags_rise | output | 16 | Per-bit failure flags, rising lane |
| flags_fall | output | 16 | Per-bit failure flags, falling lane |
| irq_status | output | 1 | Latched interrupt status |
| irq_req | output | 2 | Masked, routed interrupt requests |

## Verification
The assertions assume that the clear input comes as short pulses rather than being held across a long test. They also assume that the pattern store is not rewritten while a comparison run depends on it, and that CLEAR_RUN is at least two so that RECOVER always lasts at least one cycle. The stimulus follows these assumptions. It loads the pattern before enabling the check and pulses clear for one cycle between scenarios. It changes every control and sample input half a period away from the capturing edge, so the configuration is steady at each edge that counts.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
    localparam int NUM_WORDS = 4;
    localparam int NUM_IRQ   = 2;

    localparam logic [1:0] DEPTH_ONE = 2'd0;
    localparam logic [1:0] DEPTH_TWO = 2'd1;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CHECK,
        ST_FAIL,
        ST_RECOVER
    } chk_state_t;
endpackage

// File: rtl/pchk_pattern_store.sv
module pchk_pattern_store
    import pchk_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   we,
    input  logic [$clog2(NUM_WORDS*WIDTH/8)-1:0]   addr,
    input  logic [7:0]                             wdata,
    output logic [NUM_WORDS-1:0][WIDTH-1:0]        words
);
    localparam int BPW    = WIDTH / 8;
    localparam int NBYTES = NUM_WORDS * BPW;

    logic [7:0] bytes_q [NBYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) bytes_q[i] <= 8'h00;
        end else if (we) begin
            bytes_q[addr] <= wdata;
        end
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        for (genvar b = 0; b < BPW; b++) begin : g_byte
            assign words[k][8*b +: 8] = bytes_q[k*BPW + b];
        end
    end
endmodule

// File: rtl/pchk_sequencer.sv
module pchk_sequencer
    import pchk_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            valid,
    input  logic                            frame,
    input  logic [1:0]                      depth_sel,
    input  logic [NUM_WORDS-1:0][WIDTH-1:0] words,
    output logic [WIDTH-1:0]                exp_rise,
    output logic [WIDTH-1:0]                exp_fall
);
    logic phase_q;
    logic phase_eff;
    logic four_words;

    assign four_words = depth_sel[1];
    assign phase_eff  = frame ? 1'b0 : phase_q;

    always_comb begin
        unique case (depth_sel)
            DEPTH_ONE: begin
                exp_rise = words[0];
                exp_fall = words[0];
            end
            DEPTH_TWO: begin
                exp_rise = words[0];
                exp_fall = words[1];
            end
            default: begin
                exp_rise = words[{phase_eff, 1'b0}];
                exp_fall = words[{phase_eff, 1'b1}];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (valid) begin
            phase_q <= four_words ? ~phase_eff : 1'b0;
        end
    end

    // R4: a framed cycle at depth four leaves the next cycle on the second pair
    p_frame_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && frame && four_words) |=> phase_q);

    // R4: a shorter depth always restarts the pair sequence
    p_short_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !four_words) |=> !phase_q);
endmodule

// File: rtl/pchk_ctrl.sv
module pchk_ctrl
    import pchk_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int CLEAR_RUN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             auto_mode,
    input  logic             clear,
    input  logic             valid,
    input  logic [WIDTH-1:0] diff_rise,
    input  logic [WIDTH-1:0] diff_fall,
    output logic [WIDTH-1:0] flags_rise,
    output logic [WIDTH-1:0] flags_fall,
    output logic             irq_status
);
    localparam int               RUN_W    = $clog2(CLEAR_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(CLEAR_RUN - 1);

    chk_state_t       st_q, st_n;
    logic [WIDTH-1:0] fr_n, ff_n;
    logic             irq_n;
    logic [RUN_W-1:0] run_q, run_n;
    logic             miss;
    logic             held;

    assign miss = valid && ((|diff_rise) || (|diff_fall));
    assign held = (|flags_rise) || (|flags_fall);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_rise <= '0;
            flags_fall <= '0;
            irq_status <= 1'b0;
            run_q      <= '0;
        end else begin
            flags_rise <= fr_n;
            flags_fall <= ff_n;
            irq_status <= irq_n;
            run_q      <= run_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        fr_n  = flags_rise;
        ff_n  = flags_fall;
        irq_n = irq_status;
        run_n = run_q;
        if (clear) begin
            fr_n  = '0;
            ff_n  = '0;
            irq_n = 1'b0;
            run_n = '0;
            st_n  = enable ? ST_CHECK : ST_OFF;
        end else if (!enable) begin
            st_n = ST_OFF;
        end else if (miss) begin
            fr_n  = flags_rise | diff_rise;
            ff_n  = flags_fall | diff_fall;
            irq_n = 1'b1;
            run_n = '0;
            st_n  = ST_FAIL;
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    st_n  = held ? ST_FAIL : ST_CHECK;
                    run_n = '0;
                end
                ST_CHECK: begin
                    st_n = ST_CHECK;
                end
                ST_FAIL: begin
                    if (auto_mode && valid) begin
                        st_n  = ST_RECOVER;
                        run_n = RUN_W'(1);
                    end
                end
                ST_RECOVER: begin
                    if (!auto_mode) begin
                        st_n  = ST_FAIL;
                        run_n = '0;
                    end else if (valid) begin
                        if (run_q == RUN_LAST) begin
                            fr_n  = '0;
                            ff_n  = '0;
                            run_n = '0;
                            st_n  = ST_CHECK;
                        end else begin
                            run_n = run_q + RUN_W'(1);
                        end
                    end
                end
                default: st_n = ST_OFF;
            endcase
        end
    end

    // R6: sticky mode never drops a flag without clear
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !auto_mode) |=>
        (((flags_rise & $past(flags_rise)) == $past(flags_rise)) &&
         ((flags_fall & $past(flags_fall)) == $past(flags_fall))));

    // R7: the match-run counter stays below its limit
    p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(CLEAR_RUN));

    // R8: clear empties flags and status on the next cycle
    p_clear_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flags_rise == '0 && flags_fall == '0 && !irq_status));

    // R9: disabled comparison leaves the recorded state alone
    p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=>
        ($stable(flags_rise) && $stable(flags_fall) && $stable(irq_status)));

    // R10: status stays latched until clear
    p_irq_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !clear) |=> irq_status);

    // R10: any held flag implies a raised status
    p_flag_implies_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> irq_status);
endmodule

// File: rtl/ddr_pattern_checker.sv
module ddr_pattern_checker
    import pchk_pkg::*;
#(
    parameter int WIDTH     = 16,
    parameter int CLEAR_RUN = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 pat_we,
    input  logic [$clog2(NUM_WORDS*WIDTH/8)-1:0] pat_addr,
    input  logic [7:0]                           pat_wdata,
    input  logic                                 chk_enable,
    input  logic                                 auto_mode,
    input  logic [1:0]                           depth_sel,
    input  logic                                 flag_clear,
    input  logic                                 irq_mask,
    input  logic                                 irq_route,
    input  logic                                 smp_valid,
    input  logic                                 smp_frame,
    input  logic [WIDTH-1:0]                     smp_rise,
    input  logic [WIDTH-1:0]                     smp_fall,
    output logic [WIDTH-1:0]                     flags_rise,
    output logic [WIDTH-1:0]                     flags_fall,
    output logic                                 irq_status,
    output logic [NUM_IRQ-1:0]                   irq_req
);
    logic [NUM_WORDS-1:0][WIDTH-1:0] words;
    logic [WIDTH-1:0]                exp_rise, exp_fall;
    logic [WIDTH-1:0]                diff_rise, diff_fall;

    pchk_pattern_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pat_we),
        .addr  (pat_addr),
        .wdata (pat_wdata),
        .words (words)
    );

    pchk_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (smp_valid),
        .frame     (smp_frame),
        .depth_sel (depth_sel),
        .words     (words),
        .exp_rise  (exp_rise),
        .exp_fall  (exp_fall)
    );

    assign diff_rise = smp_rise ^ exp_rise;
    assign diff_fall = smp_fall ^ exp_fall;

    pchk_ctrl #(.WIDTH(WIDTH), .CLEAR_RUN(CLEAR_RUN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (chk_enable),
        .auto_mode  (auto_mode),
        .clear      (flag_clear),
        .valid      (smp_valid),
        .diff_rise  (diff_rise),
        .diff_fall  (diff_fall),
        .flags_rise (flags_rise),
        .flags_fall (flags_fall),
        .irq_status (irq_status)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign irq_req[i] = irq_status && irq_mask && (irq_route == i[0]);
    end

    // R10: at most one request line is active
    p_irq_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req));

    // R10: a request needs both the status and the mask
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> (irq_status && irq_mask));
endmodule

// File: tb/sim_ddr_pattern_checker.sv
module sim_ddr_pattern_checker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pat_we;
    logic [2:0]  pat_addr;
    logic [7:0]  pat_wdata;
    logic        chk_enable, auto_mode, flag_clear, irq_mask, irq_route;
    logic [1:0]  depth_sel;
    logic        smp_valid, smp_frame;
    logic [15:0] smp_rise, smp_fall;
    logic [15:0] flags_rise, flags_fall;
    logic        irq_status;
    logic [1:0]  irq_req;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] pat [4];

    always #5 clk = ~clk;

    ddr_pattern_checker u0 (
        .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .chk_enable(chk_enable), .auto_mode(auto_mode),
        .depth_sel(depth_sel), .flag_clear(flag_clear), .irq_mask(irq_mask),
        .irq_route(irq_route), .smp_valid(smp_valid), .smp_frame(smp_frame),
        .smp_rise(smp_rise), .smp_fall(smp_fall), .flags_rise(flags_rise),
        .flags_fall(flags_fall), .irq_status(irq_status), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = a; pat_wdata = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic load_pattern();
        for (int k = 0; k < 4; k++) begin
            write_byte(3'(2*k), pat[k][7:0]);
            write_byte(3'(2*k+1), pat[k][15:8]);
        end
    endtask

    task automatic send(input logic [15:0] r, input logic [15:0] f, input logic fr);
        @(negedge clk);
        smp_valid = 1'b1; smp_rise = r; smp_fall = f; smp_frame = fr;
        @(negedge clk);
        smp_valid = 1'b0; smp_frame = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 flags_rise", 32'(flags_rise), 32'h0);
        check("R11 flags_fall", 32'(flags_fall), 32'h0);
        check("R11 irq_status", 32'(irq_status), 32'h0);
        check("R11 irq_req", 32'(irq_req), 32'h0);
    endtask

    task automatic t_load();
        depth_sel = 2'd1;
        send(pat[0], pat[1], 1'b0);
        check("R1 loaded words match", 32'({flags_rise, flags_fall}), 32'h0);
        pat[1][15:8] = 8'h5A;
        write_byte(3'd3, 8'h5A);
        send(pat[0], pat[1], 1'b0);
        check("R1 odd byte lands in high half", 32'(flags_fall), 32'h0);
        send(pat[0], {pat[1][15:8], 8'h00}, 1'b0);
        check("R1 low half mismatch", 32'(flags_fall), 32'({8'h00, pat[1][7:0]}));
        pulse_clear();
    endtask

    task automatic t_depth1();
        depth_sel = 2'd0;
        send(pat[0], pat[0], 1'b0);
        check("R2 both lanes vs word 0", 32'({flags_rise, flags_fall}), 32'h0);
        send(pat[0], pat[0] ^ 16'h8000, 1'b0);
        check("R5 fall lane flag", 32'(flags_fall), 32'h8000);
        check("R5 rise lane clean", 32'(flags_rise), 32'h0);
        check("R10 status set", 32'(irq_status), 32'h1);
        pulse_clear();
    endtask

    task automatic t_depth2();
        depth_sel = 2'd1;
        send(pat[0], pat[1], 1'b0);
        send(pat[0], pat[1], 1'b0);
        check("R3 pair 0/1 repeats", 32'({flags_rise, flags_fall}), 32'h0);
        send(pat[1], pat[1], 1'b0);
        check("R3 rise vs word 0", 32'(flags_rise), 32'(pat[0] ^ pat[1]));
        pulse_clear();
    endtask

    task automatic t_depth4();
        depth_sel = 2'd2;
        send(pat[0], pat[1], 1'b0);
        send(pat[2], pat[3], 1'b0);
        send(pat[0], pat[1], 1'b0);
        check("R4 unframed alternation", 32'({flags_rise, flags_fall}), 32'h0);
        send(pat[0], pat[1], 1'b1);
        send(pat[0], pat[1], 1'b1);
        check("R4 frame forces word 0", 32'({flags_rise, flags_fall}), 32'h0);
        send(pat[2], pat[3] ^ 16'h0001, 1'b0);
        check("R4 second pair after frame", 32'(flags_fall), 32'h0001);
        check("R4 second pair rise clean", 32'(flags_rise), 32'h0);
        pulse_clear();
        depth_sel = 2'd0;
        send(pat[0], pat[0], 1'b0);
    endtask

    task automatic t_sticky();
        depth_sel = 2'd0; auto_mode = 1'b0;
        send(pat[0] ^ 16'h0008, pat[0], 1'b0);
        for (int i = 0; i < 10; i++) send(pat[0], pat[0], 1'b0);
        check("R6 sticky holds", 32'(flags_rise), 32'h0008);
        send(pat[0] ^ 16'h0020, pat[0], 1'b0);
        check("R6 sticky accumulates", 32'(flags_rise), 32'h0028);
        pulse_clear();
    endtask

    task automatic t_auto();
        depth_sel = 2'd0; auto_mode = 1'b1;
        send(pat[0] ^ 16'h0004, pat[0], 1'b0);
        for (int i = 0; i < 7; i++) send(pat[0], pat[0], 1'b0);
        check("R7 seven matches not enough", 32'(flags_rise), 32'h0004);
        send(pat[0], pat[0] ^ 16'h0010, 1'b0);
        for (int i = 0; i < 7; i++) send(pat[0], pat[0], 1'b0);
        check("R7 run restarted", 32'({flags_rise, flags_fall}), 32'h0004_0010);
        send(pat[0], pat[0], 1'b0);
        check("R7 eighth match clears", 32'({flags_rise, flags_fall}), 32'h0);
        check("R7 status kept", 32'(irq_status), 32'h1);
        auto_mode = 1'b0;
        pulse_clear();
    endtask

    task automatic t_clear();
        depth_sel = 2'd0;
        send(pat[0] ^ 16'h0100, pat[0], 1'b0);
        @(negedge clk);
        flag_clear = 1'b1; smp_valid = 1'b1; smp_rise = ~pat[0]; smp_fall = pat[0];
        @(negedge clk);
        flag_clear = 1'b0; smp_valid = 1'b0;
        check("R8 clear wins flags", 32'({flags_rise, flags_fall}), 32'h0);
        check("R8 clear wins status", 32'(irq_status), 32'h0);
    endtask

    task automatic t_disable();
        depth_sel = 2'd0; chk_enable = 1'b0;
        send(~pat[0], ~pat[0], 1'b0);
        send(16'h0, 16'hFFFF, 1'b0);
        check("R9 ignored flags", 32'({flags_rise, flags_fall}), 32'h0);
        check("R9 ignored status", 32'(irq_status), 32'h0);
        chk_enable = 1'b1;
        send(pat[0], pat[0], 1'b0);
        check("R9 re-enable clean", 32'({flags_rise, flags_fall}), 32'h0);
    endtask

    task automatic t_irq();
        depth_sel = 2'd0;
        irq_mask = 1'b0; irq_route = 1'b0;
        send(pat[0] ^ 16'h0001, pat[0], 1'b0);
        check("R10 masked", 32'(irq_req), 32'h0);
        @(negedge clk); irq_mask = 1'b1; #1;
        check("R10 route 0", 32'(irq_req), 32'h1);
        @(negedge clk); irq_route = 1'b1; #1;
        check("R10 route 1", 32'(irq_req), 32'h2);
        pulse_clear();
        #1;
        check("R10 cleared request", 32'(irq_req), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        pat[0] = 16'hA5C3; pat[1] = 16'h1234; pat[2] = 16'h0F0F; pat[3] = 16'hC001;
        rst_n = 1'b0; pat_we = 1'b0; pat_addr = '0; pat_wdata = '0;
        chk_enable = 1'b0; auto_mode = 1'b0; depth_sel = 2'd0; flag_clear = 1'b0;
        irq_mask = 1'b0; irq_route = 1'b0; smp_valid = 1'b0; smp_frame = 1'b0;
        smp_rise = '0; smp_fall = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_pattern();
        chk_enable = 1'b1;
        t_load();
        t_depth1();
        t_depth2();
        t_depth4();
        t_sticky();
        t_auto();
        t_clear();
        t_disable();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule